// File: doc/BRIEF.md
# GPIO Pad Local Control Cell

This cell sits beside a single general-purpose I/O pad. It keeps a private 13-bit configuration register. The register copies the configuration word presented at its input, but only in a cycle where the transfer strobe is high. All the static pad controls come straight from that register: drive mode, trip point, slew, the analog-bus bits, input disable and hold value.

The cell also routes the three dynamic pad signals: output value, active-low output enable and input. Bit 0 of the register decides who owns them. When the bit is 1 the management side owns them; when it is 0 the user logic owns them.

A build parameter chooses between two pad types:

- **Full-management pad.** The management side has a separate output, output enable and input.
- **Ordinary pad.** Management has a single logical wire. Its direction follows the output-disable bit. It returns the pad input when that bit is 1 and supplies the pad output value when it is 0.

On an ordinary pad under management control, the pull-up and pull-down drive modes force the pad output locally. The forced value is the inverse of drive-mode bit 0. The wire still returns the input in these modes.

Top module: `pad_ctl_cell`

## Requirements
- R1: With FULL_MGMT=0, after reset the register holds 13'h0403: drive mode 001 in bits 12..10, output disable (bit 1) = 1, management ownership (bit 0) = 1. So pad_static_o = 11'h100 and pad_oe_n_o = 1.
- R2: With FULL_MGMT=1, after reset the register holds 13'h1801: drive mode 110 and ownership bit 0 = 1. So pad_static_o = 11'h600.
- R3: The register takes cfg_word_i at a rising clock edge where cfg_load_i is 1, and outputs show the new value after that edge. At any other edge a change on cfg_word_i leaves every output unchanged.
- R4: When register bit 0 is 0, pad_out_o equals usr_out_i and pad_oe_n_o equals the inverse of usr_oe_i, whatever the drive mode.
- R5: On a full-management pad with bit 0 = 1, pad_out_o equals mgmt_out_i and pad_oe_n_o equals the inverse of mgmt_oe_i. Bit 1 has no effect, and mgmt_in_o always equals pad_in_i.
- R6: On an ordinary pad with bit 1 = 1, mgmt_in_o returns pad_in_i. With bit 0 = 1 as well, pad_oe_n_o = 1.
- R7: On an ordinary pad with bit 1 = 0, mgmt_in_o is 0. With bit 0 = 1 as well, pad_out_o equals mgmt_out_i and pad_oe_n_o = 0.
- R8: On an ordinary pad with bit 0 = 1 and drive mode 010 (pull-up) or 011 (pull-down), pad_out_o is the inverse of register bit 10. That gives 1 for pull-up and 0 for pull-down, whatever mgmt_out_i is.
- R9: usr_in_o always equals pad_in_i.
- R10: pad_static_o always equals register bits 12..2 (pad_static_o[0] = bit 2), whichever side owns the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_word_i | input | 13 | Configuration word offered for transfer |
| cfg_load_i | input | 1 | Transfer strobe; register copies cfg_word_i |
| pad_in_i | input | 1 | Digital input from the pad |
| pad_out_o | output | 1 | Output value to the pad |
| pad_oe_n_o | output | 1 | Active-low output enable to the pad |
| pad_static_o | output | 11 | Static pad controls (register bits 12..2) |
| usr_out_i | input | 1 | User output value |
| usr_oe_i | input | 1 | User output enable, active high |
| usr_in_o | output | 1 | Pad input forwarded to user logic |
| mgmt_out_i | input | 1 | Management output value, or the driving direction of the shared wire |
| mgmt_oe_i | input | 1 | Management output enable (full-management pad only) |
| mgmt_in_o | output | 1 | Pad input returned to management, or the returning direction of the shared wire |

## Verification
The bench goes after four traps:

- **Unstrobed change.** A config word that changes without a strobe must not leak through. A register written as a transparent latch, or without the enable, would change the static outputs early.
- **Forced pull value.** The pull modes are driven with the opposite management value. A design that forgets the local force, or inverts the wrong drive-mode bit, shows the management value, or the same level for both modes, on the pad.
- **Shared-wire direction.** The wire is tested in both directions. A swapped polarity would return the input while driving the pad, or enable the pad while the wire is listening.
- **Ignored disable bit.** On the full-management pad, bit 1 is toggled. A variant that honours it would change the pad enable.

// File: rtl/gpio_cell_pkg.sv
`timescale 1ns/1ps
// Package: field positions and helpers shared by the pad control cell.
// Assumes the 13-bit configuration layout below is fixed by the pad.
package gpio_cell_pkg;
    localparam int CFG_W    = 13;
    localparam int DM_W     = 3;
    localparam int STAT_LSB = 2;
    localparam int STAT_W   = CFG_W - STAT_LSB;
    localparam int DM_LSB   = CFG_W - DM_W;
    localparam int OWN_BIT  = 0;
    localparam int ODIS_BIT = 1;

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [DM_W-1:0]  dmode_t;

    localparam cfg_t RST_ORDINARY = 13'h0403;
    localparam cfg_t RST_FULL     = 13'h1801;

    localparam dmode_t DM_PULLUP   = 3'b010;
    localparam dmode_t DM_PULLDOWN = 3'b011;

    // True for the two drive modes where the output is forced locally.
    function automatic logic is_pull_mode(input dmode_t dm);
        return (dm == DM_PULLUP) || (dm == DM_PULLDOWN);
    endfunction
endpackage

// File: rtl/pad_cfg_reg.sv
`timescale 1ns/1ps
// Holds the local configuration copy. It loads only on the transfer strobe.
// Assumes the strobe is synchronous to clk_i. Reset is synchronous, active low.
module pad_cfg_reg
    import gpio_cell_pkg::*;
#(
    parameter cfg_t RST_VAL = RST_ORDINARY
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  cfg_t word_i,
    input  logic load_i,
    output cfg_t cfg_o
);
    cfg_t cfg_q;

    // Capture the offered word on a strobe; otherwise hold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= RST_VAL;
        end else if (load_i) begin
            cfg_q <= word_i;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/pad_route.sv
`timescale 1ns/1ps
// Routes output, enable and input between the pad and its current owner.
// FULL_MGMT picks the full three-signal management path or the single shared wire.
// Assumes cfg_i comes from the local register (no combinational path from the bus).
module pad_route
    import gpio_cell_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  cfg_t cfg_i,
    input  logic pad_in_i,
    output logic pad_out_o,
    output logic pad_oe_n_o,
    input  logic usr_out_i,
    input  logic usr_oe_i,
    output logic usr_in_o,
    input  logic mgmt_out_i,
    input  logic mgmt_oe_i,
    output logic mgmt_in_o
);
    logic   own_mgmt;
    logic   out_dis;
    dmode_t dmode;
    logic   m_out;
    logic   m_oe_n;

    assign own_mgmt = cfg_i[OWN_BIT];
    assign out_dis  = cfg_i[ODIS_BIT];
    assign dmode    = cfg_i[CFG_W-1:DM_LSB];
    assign usr_in_o = pad_in_i;

    generate
        if (FULL_MGMT) begin : g_full
            // Dedicated management signals; the disable bit plays no part.
            always_comb begin
                m_out     = mgmt_out_i;
                m_oe_n    = ~mgmt_oe_i;
                mgmt_in_o = pad_in_i;
            end
        end else begin : g_shared
            logic unused_mgmt_oe;
            assign unused_mgmt_oe = mgmt_oe_i;
            // Shared wire: direction from the disable bit, pull modes force the value.
            always_comb begin
                m_oe_n    = out_dis;
                mgmt_in_o = out_dis ? pad_in_i : 1'b0;
                if (is_pull_mode(dmode)) begin
                    m_out = ~dmode[0];
                end else begin
                    m_out = mgmt_out_i;
                end
            end
        end
    endgenerate

    // Pick the owner of the dynamic pad signals.
    always_comb begin
        if (own_mgmt) begin
            pad_out_o  = m_out;
            pad_oe_n_o = m_oe_n;
        end else begin
            pad_out_o  = usr_out_i;
            pad_oe_n_o = ~usr_oe_i;
        end
    end
endmodule

// File: rtl/pad_ctl_cell.sv
`timescale 1ns/1ps
// Top of the per-pad control cell: local config register, static outputs
// and dynamic routing. FULL_MGMT=1 builds the full-management pad type
// (its own reset value and three management signals).
module pad_ctl_cell
    import gpio_cell_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CFG_W-1:0]  cfg_word_i,
    input  logic              cfg_load_i,
    input  logic              pad_in_i,
    output logic              pad_out_o,
    output logic              pad_oe_n_o,
    output logic [STAT_W-1:0] pad_static_o,
    input  logic              usr_out_i,
    input  logic              usr_oe_i,
    output logic              usr_in_o,
    input  logic              mgmt_out_i,
    input  logic              mgmt_oe_i,
    output logic              mgmt_in_o
);
    localparam cfg_t RST_VAL = FULL_MGMT ? RST_FULL : RST_ORDINARY;

    cfg_t cfg_q;

    pad_cfg_reg #(.RST_VAL(RST_VAL)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .word_i (cfg_word_i),
        .load_i (cfg_load_i),
        .cfg_o  (cfg_q)
    );

    // Static controls pass straight through from the register.
    assign pad_static_o = cfg_q[CFG_W-1:STAT_LSB];

    pad_route #(.FULL_MGMT(FULL_MGMT)) u_route (
        .cfg_i      (cfg_q),
        .pad_in_i   (pad_in_i),
        .pad_out_o  (pad_out_o),
        .pad_oe_n_o (pad_oe_n_o),
        .usr_out_i  (usr_out_i),
        .usr_oe_i   (usr_oe_i),
        .usr_in_o   (usr_in_o),
        .mgmt_out_i (mgmt_out_i),
        .mgmt_oe_i  (mgmt_oe_i),
        .mgmt_in_o  (mgmt_in_o)
    );
endmodule

// File: rtl/pad_ctl_cell_chk.sv
`timescale 1ns/1ps
// Checker for pad_ctl_cell. Bound to every instance; relates the ports
// to the register copy over time.
module pad_ctl_cell_chk
    import gpio_cell_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CFG_W-1:0]  cfg_word_i,
    input logic              cfg_load_i,
    input logic              pad_in_i,
    input logic              pad_out_o,
    input logic              pad_oe_n_o,
    input logic [STAT_W-1:0] pad_static_o,
    input logic              usr_out_i,
    input logic              usr_oe_i,
    input logic              usr_in_o,
    input logic              mgmt_out_i,
    input logic              mgmt_oe_i,
    input logic              mgmt_in_o,
    input logic [CFG_W-1:0]  cfg_q
);
    localparam logic [CFG_W-1:0] RSTV = FULL_MGMT ? RST_FULL : RST_ORDINARY;

    // R1, R2: the first cycle out of reset shows the pad-type default.
    assert_reset_val_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> cfg_q == RSTV);

    // R3: a strobe copies the offered word.
    assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_i |=> pad_static_o == $past(cfg_word_i[CFG_W-1:STAT_LSB]));

    // R3: no strobe, no change.
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_load_i |=> $stable(pad_static_o) && $stable(cfg_q));

    // R4: user ownership.
    assert_user_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_q[OWN_BIT] |-> pad_out_o == usr_out_i && pad_oe_n_o == !usr_oe_i);

    // R5: full-management pad follows its dedicated management signals.
    assert_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (FULL_MGMT && cfg_q[OWN_BIT]) |-> pad_out_o == mgmt_out_i && pad_oe_n_o == !mgmt_oe_i);

    // R7: the shared wire drives the pad when the disable bit is clear.
    assert_wire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!FULL_MGMT && cfg_q[OWN_BIT] && !cfg_q[ODIS_BIT]) |-> !pad_oe_n_o && !mgmt_in_o);

    // R8: the pull modes force the output from the drive-mode bits.
    assert_pull_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!FULL_MGMT && cfg_q[OWN_BIT] && is_pull_mode(cfg_q[CFG_W-1:DM_LSB]))
            |-> pad_out_o == !cfg_q[DM_LSB]);

    // R9: user input always follows the pad.
    assert_usr_in_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        usr_in_o == pad_in_i);
endmodule

bind pad_ctl_cell pad_ctl_cell_chk #(.FULL_MGMT(FULL_MGMT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_word_i   (cfg_word_i),
    .cfg_load_i   (cfg_load_i),
    .pad_in_i     (pad_in_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_n_o   (pad_oe_n_o),
    .pad_static_o (pad_static_o),
    .usr_out_i    (usr_out_i),
    .usr_oe_i     (usr_oe_i),
    .usr_in_o     (usr_in_o),
    .mgmt_out_i   (mgmt_out_i),
    .mgmt_oe_i    (mgmt_oe_i),
    .mgmt_in_o    (mgmt_in_o),
    .cfg_q        (cfg_q)
);

// File: tb/tb_pad_ctl_cell.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected output vectors for both pad
// types; the monitor pops each and compares it with the live outputs.
module tb_pad_ctl_cell;
    typedef struct {
        string       rq;
        logic [14:0] exp_n;
        logic [14:0] exp_f;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cfg_word = 13'h0;
    logic        cfg_load = 1'b0;
    logic        pad_in = 1'b0, usr_out = 1'b0, usr_oe = 1'b0;
    logic        mgmt_out = 1'b0, mgmt_oe = 1'b0;

    logic        po_n, oe_n_n, ui_n, mi_n;
    logic [10:0] st_n;
    logic        po_f, oe_n_f, ui_f, mi_f;
    logic [10:0] st_f;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    item_t sb[$];

    // Model copies of the two registers.
    logic [12:0] m_cfg_n = 13'h0403;
    logic [12:0] m_cfg_f = 13'h1801;

    always #2.5 clk = ~clk;

    pad_ctl_cell #(.FULL_MGMT(1'b0)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_word_i(cfg_word), .cfg_load_i(cfg_load),
        .pad_in_i(pad_in), .pad_out_o(po_n), .pad_oe_n_o(oe_n_n), .pad_static_o(st_n),
        .usr_out_i(usr_out), .usr_oe_i(usr_oe), .usr_in_o(ui_n),
        .mgmt_out_i(mgmt_out), .mgmt_oe_i(mgmt_oe), .mgmt_in_o(mi_n));

    pad_ctl_cell #(.FULL_MGMT(1'b1)) dut_full (
        .clk_i(clk), .rst_ni(rst_n), .cfg_word_i(cfg_word), .cfg_load_i(cfg_load),
        .pad_in_i(pad_in), .pad_out_o(po_f), .pad_oe_n_o(oe_n_f), .pad_static_o(st_f),
        .usr_out_i(usr_out), .usr_oe_i(usr_oe), .usr_in_o(ui_f),
        .mgmt_out_i(mgmt_out), .mgmt_oe_i(mgmt_oe), .mgmt_in_o(mi_f));

    // Expected {pad_out, oe_n, mgmt_in, usr_in, static[10:0]} from the requirements.
    function automatic logic [14:0] model(input bit full, input logic [12:0] c);
        logic po, oen, mi;
        logic [2:0] dm;
        dm = c[12:10];
        if (full) begin
            mi  = pad_in;
            po  = mgmt_out;
            oen = ~mgmt_oe;
        end else begin
            mi  = c[1] ? pad_in : 1'b0;
            oen = c[1];
            po  = (dm == 3'b010 || dm == 3'b011) ? ~dm[0] : mgmt_out;
        end
        if (!c[0]) begin
            po  = usr_out;
            oen = ~usr_oe;
        end
        return {po, oen, mi, pad_in, c[12:2]};
    endfunction

    // Driver: push one expected item and wait until the monitor has taken it.
    task automatic expect_now(input string rq);
        item_t it;
        #1;
        it.rq    = rq;
        it.exp_n = model(1'b0, m_cfg_n);
        it.exp_f = model(1'b1, m_cfg_f);
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic load(input logic [12:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_cfg_n  = w;
        m_cfg_f  = w;
    endtask

    task automatic drive(input logic pi, input logic uo, input logic uoe,
                         input logic mo, input logic moe);
        @(negedge clk);
        pad_in = pi; usr_out = uo; usr_oe = uoe; mgmt_out = mo; mgmt_oe = moe;
    endtask

    // Monitor: compare each popped item with the present outputs.
    initial begin
        forever begin
            item_t it;
            logic [14:0] act_n, act_f;
            wait (sb.size() != 0);
            it    = sb.pop_front();
            act_n = {po_n, oe_n_n, mi_n, ui_n, st_n};
            act_f = {po_f, oe_n_f, mi_f, ui_f, st_f};
            checks = checks + 1;
            if (act_n !== it.exp_n) begin
                fails = fails + 1;
                $display("FAIL %s ordinary pad: actual=%h expected=%h", it.rq, act_n, it.exp_n);
            end
            checks = checks + 1;
            if (act_f !== it.exp_f) begin
                fails = fails + 1;
                $display("FAIL %s full pad: actual=%h expected=%h", it.rq, act_f, it.exp_f);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 R2 reset defaults");

        drive(1, 0, 0, 1, 1); expect_now("R6 R5 R9 input 1");
        drive(0, 1, 0, 0, 0); expect_now("R6 R5 R9 input 0");

        // R3: offer a word without a strobe over several edges.
        @(negedge clk); cfg_word = 13'h1FFE;
        repeat (3) @(negedge clk);
        expect_now("R3 no transfer");

        load(13'h0402); drive(1, 1, 1, 0, 0); expect_now("R4 user drive");
        drive(0, 0, 0, 1, 1); expect_now("R4 R9 user input");

        load(13'h0401); drive(1, 1, 1, 1, 0); expect_now("R7 R5 wire drives 1");
        drive(0, 0, 0, 0, 1); expect_now("R7 R5 wire drives 0");

        load(13'h0803); drive(1, 0, 0, 0, 0); expect_now("R8 pull-up forced");
        load(13'h0C03); drive(0, 0, 0, 1, 1); expect_now("R8 pull-down forced");
        drive(1, 0, 0, 1, 0); expect_now("R8 R6 pull-down returns input");

        load(13'h0802); drive(0, 0, 1, 0, 0); expect_now("R4 pull mode user owned");

        load(13'h1FFC); drive(1, 1, 0, 0, 1); expect_now("R10 static all ones");
        load(13'h0AA9); expect_now("R10 static pattern");
        load(13'h1557); expect_now("R10 R6 static pattern mgmt");

        @(negedge clk); cfg_word = 13'h0000;
        @(negedge clk); expect_now("R3 hold after change");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule